// File: doc/BRIEF.md
# Virtualization-Aware Tagged Translation Cache

This block is a sixteen-slot, fully associative cache of address translations for a processor that runs guests. Each slot holds one of three entry kinds. A linear entry is tagged with a virtual-processor ID and a process-context ID. A combined entry carries both of those tags plus a nested-table root tag. A guest-physical entry carries only the root tag. The lookup port is combinational. It takes a page number, an address kind, the current tags and a nested-paging flag. In the same cycle it reports a hit and the stored frame. Which entry kinds may answer depends on the nested-paging flag. Entries of a kind the current mode cannot use are kept, and they answer again once the mode switches back.

A fill port writes one new entry per cycle into a round-robin victim slot. An invalidation port runs four flush commands, and each one clears matching slots within the cycle. A single-page flush clears linear and combined entries for the current VPID and one page, for every root tag. A nested-fault flush clears one guest-physical page, and optionally the combined entry for the linear page that faulted. A world-switch flush clears everything tagged VPID 0. An individual-address flush clears entries for a given VPID and page. Any other command code is dropped, and it raises a one-cycle rejection flag. A small state machine drives that flag. It has two states: CMD_READY, and CMD_REJECT, in which the flag is high. The transition READY→REJECT fires on an unsupported command. REJECT→REJECT fires when another unsupported command follows. REJECT→READY fires on anything else.

Top module: `vtlb_tag_cache`

## Requirements
- R1: With nest_en=0, a lookup with lk_gpa=0 hits only valid linear entries (kind 0) whose VPID equals cur_vpid, whose page equals lk_page, and whose PCID equals cur_pcid or whose global bit is set. A lookup with lk_gpa=1 always misses, and combined entries never hit.
- R2: With nest_en=1, a lookup with lk_gpa=0 hits only valid combined entries (kind 1) that match cur_vpid, cur_root and lk_page, with a PCID match or the global bit set. Linear entries never hit.
- R3: With nest_en=1, a lookup with lk_gpa=1 hits valid guest-physical entries (kind 2) whose root tag equals cur_root and whose page equals lk_page, regardless of VPID and PCID.
- R4: A change of nest_en invalidates nothing. An entry that cannot hit in one mode hits again after the mode returns.
- R5: Command 0 (single page) clears every linear and combined entry with VPID equal to cur_vpid and page equal to inv_page, for all PCIDs and root tags, in either mode.
- R6: Command 1 (nested fault) clears guest-physical entries with root equal to cur_root and page equal to inv_page. When inv_lin_valid=1 it also clears combined entries with page inv_lin_page, VPID cur_vpid, root cur_root, and a PCID equal to cur_pcid or the global bit set.
- R7: Command 2 (world switch, VPID tagging off) clears every linear and combined entry with VPID 0, for all PCIDs and root tags.
- R8: Command 3 (individual address) clears every linear and combined entry with VPID equal to inv_vpid and page equal to inv_page, for all PCIDs and root tags.
- R9: Command codes 4 to 7 change no entry. inv_unsup is high in exactly the cycle after each such command and is low otherwise.
- R10: A fill writes the slot at the victim pointer, and the pointer then advances by one modulo 16, so the seventeenth fill overwrites the first of sixteen consecutive fills. A fill with fill_kind=3 writes nothing and does not advance the pointer.
- R11: When inv_en=1, a fill in the same cycle is dropped and the pointer holds. A lookup in the same cycle as a flush still sees the entries as they were before the flush.
- R12: After reset all slots are invalid, every lookup misses and inv_unsup is low. When several slots hit, the frame comes from the lowest-numbered slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nest_en | input | 1 | Nested paging enabled |
| cur_vpid | input | 16 | Current virtual-processor ID |
| cur_pcid | input | 12 | Current process-context ID |
| cur_root | input | 12 | Current nested-table root tag |
| lk_gpa | input | 1 | Lookup address kind: 0 linear, 1 guest-physical |
| lk_page | input | 20 | Lookup page number |
| lk_hit | output | 1 | Lookup hit |
| lk_frame | output | 20 | Frame of the hitting entry, 0 on a miss |
| fill_en | input | 1 | Write a new entry |
| fill_kind | input | 2 | Entry kind: 0 linear, 1 combined, 2 guest-physical, 3 none |
| fill_global | input | 1 | Global bit of the new entry |
| fill_vpid | input | 16 | VPID of the new entry |
| fill_pcid | input | 12 | PCID of the new entry |
| fill_root | input | 12 | Root tag of the new entry |
| fill_page | input | 20 | Page of the new entry |
| fill_frame | input | 20 | Frame of the new entry |
| inv_en | input | 1 | Flush command valid |
| inv_cmd | input | 3 | Flush command code |
| inv_page | input | 20 | Page operand (linear or guest-physical) |
| inv_vpid | input | 16 | VPID operand of the individual-address flush |
| inv_lin_valid | input | 1 | Nested fault came from a linear address |
| inv_lin_page | input | 20 | Linear page of the nested fault |
| inv_unsup | output | 1 | Previous command code was unsupported |

## Verification
A slot whose valid bit, kind or tag is wrong shows up as a hit or a miss that disagrees with the model. Because the lookup is combinational, this is visible in the first lookup that touches that slot, even in the same cycle as a flush. A flush match that is too wide or too narrow shows up in the probe that follows the flush. A victim pointer that is off by one only shows up on a later fill, when the wrong page disappears. For that reason the bench fills every slot and checks which page the next fill evicts. A rejection state machine stuck in either state is caught one cycle after any command.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

    localparam int VPID_W  = 16;
    localparam int PCID_W  = 12;
    localparam int ROOT_W  = 12;
    localparam int PAGE_W  = 20;
    localparam int FRAME_W = 20;
    localparam int CMD_W   = 3;

    typedef enum logic [1:0] {
        KIND_LIN  = 2'd0,
        KIND_COMB = 2'd1,
        KIND_GPA  = 2'd2,
        KIND_NONE = 2'd3
    } kind_e;

    localparam logic [CMD_W-1:0] CMD_PAGE   = 3'd0;
    localparam logic [CMD_W-1:0] CMD_NFAULT = 3'd1;
    localparam logic [CMD_W-1:0] CMD_WORLD  = 3'd2;
    localparam logic [CMD_W-1:0] CMD_INDIV  = 3'd3;

    typedef enum logic {
        CMD_READY  = 1'b0,
        CMD_REJECT = 1'b1
    } cstate_e;

    typedef struct packed {
        logic               valid;
        kind_e              kind;
        logic               glob;
        logic [VPID_W-1:0]  vpid;
        logic [PCID_W-1:0]  pcid;
        logic [ROOT_W-1:0]  root;
        logic [PAGE_W-1:0]  page;
        logic [FRAME_W-1:0] frame;
    } ent_t;

endpackage

// File: rtl/vtlb_cmd_fsm.sv
module vtlb_cmd_fsm
    import vtlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_en,
    input  logic [CMD_W-1:0] inv_cmd,
    output logic             do_page,
    output logic             do_nfault,
    output logic             do_world,
    output logic             do_indiv,
    output logic             inv_unsup
);

    cstate_e state_q;
    cstate_e state_d;
    logic    bad_cmd;

    assign bad_cmd = inv_en && (inv_cmd > CMD_INDIV);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CMD_READY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_READY:  state_d = bad_cmd ? CMD_REJECT : CMD_READY;
            CMD_REJECT: state_d = bad_cmd ? CMD_REJECT : CMD_READY;
        endcase
    end

    always_comb begin
        inv_unsup = (state_q == CMD_REJECT);
        do_page   = inv_en && (inv_cmd == CMD_PAGE);
        do_nfault = inv_en && (inv_cmd == CMD_NFAULT);
        do_world  = inv_en && (inv_cmd == CMD_WORLD);
        do_indiv  = inv_en && (inv_cmd == CMD_INDIV);
    end

endmodule

// File: rtl/vtlb_rr_ptr.sv
module vtlb_rr_ptr #(
    parameter int N_ENT = 16,
    localparam int PTR_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == PTR_W'(N_ENT - 1)) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/vtlb_entry_cmp.sv
module vtlb_entry_cmp
    import vtlb_pkg::*;
(
    input  ent_t              ent,
    input  logic              nest_en,
    input  logic              lk_gpa,
    input  logic [PAGE_W-1:0] lk_page,
    input  logic [VPID_W-1:0] cur_vpid,
    input  logic [PCID_W-1:0] cur_pcid,
    input  logic [ROOT_W-1:0] cur_root,
    input  logic              do_page,
    input  logic              do_nfault,
    input  logic              do_world,
    input  logic              do_indiv,
    input  logic [PAGE_W-1:0] inv_page,
    input  logic [VPID_W-1:0] inv_vpid,
    input  logic              inv_lin_valid,
    input  logic [PAGE_W-1:0] inv_lin_page,
    output logic              hit,
    output logic              kill
);

    logic is_lin, is_comb, is_gpa, lin_like;
    logic vpid_cur, pcid_ok, root_cur;

    always_comb begin
        is_lin   = ent.valid && (ent.kind == KIND_LIN);
        is_comb  = ent.valid && (ent.kind == KIND_COMB);
        is_gpa   = ent.valid && (ent.kind == KIND_GPA);
        lin_like = is_lin || is_comb;
        vpid_cur = (ent.vpid == cur_vpid);
        pcid_ok  = ent.glob || (ent.pcid == cur_pcid);
        root_cur = (ent.root == cur_root);
    end

    always_comb begin
        hit = 1'b0;
        if (ent.page == lk_page) begin
            if (!nest_en) begin
                hit = !lk_gpa && is_lin && vpid_cur && pcid_ok;
            end else if (lk_gpa) begin
                hit = is_gpa && root_cur;
            end else begin
                hit = is_comb && vpid_cur && pcid_ok && root_cur;
            end
        end
    end

    always_comb begin
        kill = 1'b0;
        if (do_page) begin
            kill = lin_like && vpid_cur && (ent.page == inv_page);
        end
        if (do_nfault) begin
            kill = (is_gpa && root_cur && (ent.page == inv_page)) ||
                   (inv_lin_valid && is_comb && vpid_cur && root_cur &&
                    pcid_ok && (ent.page == inv_lin_page));
        end
        if (do_world) begin
            kill = lin_like && (ent.vpid == '0);
        end
        if (do_indiv) begin
            kill = lin_like && (ent.vpid == inv_vpid) && (ent.page == inv_page);
        end
    end

endmodule

// File: rtl/vtlb_tag_cache.sv
module vtlb_tag_cache
    import vtlb_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int PTR_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nest_en,
    input  logic [VPID_W-1:0]  cur_vpid,
    input  logic [PCID_W-1:0]  cur_pcid,
    input  logic [ROOT_W-1:0]  cur_root,
    input  logic               lk_gpa,
    input  logic [PAGE_W-1:0]  lk_page,
    output logic               lk_hit,
    output logic [FRAME_W-1:0] lk_frame,
    input  logic               fill_en,
    input  logic [1:0]         fill_kind,
    input  logic               fill_global,
    input  logic [VPID_W-1:0]  fill_vpid,
    input  logic [PCID_W-1:0]  fill_pcid,
    input  logic [ROOT_W-1:0]  fill_root,
    input  logic [PAGE_W-1:0]  fill_page,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic               inv_en,
    input  logic [CMD_W-1:0]   inv_cmd,
    input  logic [PAGE_W-1:0]  inv_page,
    input  logic [VPID_W-1:0]  inv_vpid,
    input  logic               inv_lin_valid,
    input  logic [PAGE_W-1:0]  inv_lin_page,
    output logic               inv_unsup
);

    ent_t             ent_q [N_ENT];
    logic [N_ENT-1:0] hit_vec;
    logic [N_ENT-1:0] kill_vec;
    logic             do_page, do_nfault, do_world, do_indiv;
    logic             fill_wr;
    logic [PTR_W-1:0] vic_ptr;
    ent_t             fill_ent;

    vtlb_cmd_fsm u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv_en    (inv_en),
        .inv_cmd   (inv_cmd),
        .do_page   (do_page),
        .do_nfault (do_nfault),
        .do_world  (do_world),
        .do_indiv  (do_indiv),
        .inv_unsup (inv_unsup)
    );

    assign fill_wr = fill_en && !inv_en && (kind_e'(fill_kind) != KIND_NONE);

    vtlb_rr_ptr #(.N_ENT(N_ENT)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (fill_wr),
        .ptr   (vic_ptr)
    );

    always_comb begin
        fill_ent.valid = 1'b1;
        fill_ent.kind  = kind_e'(fill_kind);
        fill_ent.glob  = fill_global;
        fill_ent.vpid  = fill_vpid;
        fill_ent.pcid  = fill_pcid;
        fill_ent.root  = fill_root;
        fill_ent.page  = fill_page;
        fill_ent.frame = fill_frame;
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        vtlb_entry_cmp u_cmp (
            .ent           (ent_q[g]),
            .nest_en       (nest_en),
            .lk_gpa        (lk_gpa),
            .lk_page       (lk_page),
            .cur_vpid      (cur_vpid),
            .cur_pcid      (cur_pcid),
            .cur_root      (cur_root),
            .do_page       (do_page),
            .do_nfault     (do_nfault),
            .do_world      (do_world),
            .do_indiv      (do_indiv),
            .inv_page      (inv_page),
            .inv_vpid      (inv_vpid),
            .inv_lin_valid (inv_lin_valid),
            .inv_lin_page  (inv_lin_page),
            .hit           (hit_vec[g]),
            .kill          (kill_vec[g])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else if (kill_vec[g]) begin
                ent_q[g].valid <= 1'b0;
            end else if (fill_wr && (vic_ptr == PTR_W'(g))) begin
                ent_q[g] <= fill_ent;
            end
        end
    end

    always_comb begin
        lk_hit   = 1'b0;
        lk_frame = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                lk_hit   = 1'b1;
                lk_frame = ent_q[i].frame;
            end
        end
    end

endmodule

// File: rtl/vtlb_tag_cache_chk.sv
module vtlb_tag_cache_chk #(
    parameter int N_ENT = 16,
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             nest_en,
    input logic             lk_gpa,
    input logic             lk_hit,
    input logic             fill_en,
    input logic [1:0]       fill_kind,
    input logic             inv_en,
    input logic [2:0]       inv_cmd,
    input logic             inv_unsup,
    input logic [PTR_W-1:0] vic_ptr
);

    AST_GPA_MISS_NEST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_en && lk_gpa) |-> !lk_hit); // R1

    AST_UNSUP_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && inv_cmd > 3'd3) |=> inv_unsup); // R9

    AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_en && inv_cmd > 3'd3) |=> !inv_unsup); // R9

    AST_FLUSH_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> $stable(vic_ptr)); // R11

    AST_FILL_STEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !inv_en && fill_kind != 2'd3) |=>
        (vic_ptr == (($past(vic_ptr) == PTR_W'(N_ENT - 1)) ? '0 : $past(vic_ptr) + 1'b1))); // R10

    AST_NOFILL_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en || fill_kind == 2'd3) |=> $stable(vic_ptr)); // R10

endmodule

bind vtlb_tag_cache vtlb_tag_cache_chk #(.N_ENT(N_ENT), .PTR_W(PTR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .nest_en   (nest_en),
    .lk_gpa    (lk_gpa),
    .lk_hit    (lk_hit),
    .fill_en   (fill_en),
    .fill_kind (fill_kind),
    .inv_en    (inv_en),
    .inv_cmd   (inv_cmd),
    .inv_unsup (inv_unsup),
    .vic_ptr   (vic_ptr)
);

// File: tb/vtlb_tag_cache_tb.sv
module vtlb_tag_cache_tb_top;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nest_en = 1'b0;
    logic [15:0] cur_vpid = '0;
    logic [11:0] cur_pcid = '0;
    logic [11:0] cur_root = '0;
    logic        lk_gpa = 1'b0;
    logic [19:0] lk_page = '0;
    logic        lk_hit;
    logic [19:0] lk_frame;
    logic        fill_en = 1'b0;
    logic [1:0]  fill_kind = '0;
    logic        fill_global = 1'b0;
    logic [15:0] fill_vpid = '0;
    logic [11:0] fill_pcid = '0;
    logic [11:0] fill_root = '0;
    logic [19:0] fill_page = '0;
    logic [19:0] fill_frame = '0;
    logic        inv_en = 1'b0;
    logic [2:0]  inv_cmd = '0;
    logic [19:0] inv_page = '0;
    logic [15:0] inv_vpid = '0;
    logic        inv_lin_valid = 1'b0;
    logic [19:0] inv_lin_page = '0;
    logic        inv_unsup;

    int checks = 0;
    int errors = 0;

    logic        m_val   [N];
    logic [1:0]  m_kind  [N];
    logic        m_glob  [N];
    logic [15:0] m_vpid  [N];
    logic [11:0] m_pcid  [N];
    logic [11:0] m_root  [N];
    logic [19:0] m_page  [N];
    logic [19:0] m_frame [N];
    int          m_ptr = 0;
    logic        m_unsup = 1'b0;

    always #5 clk = ~clk;

    vtlb_tag_cache dut_i (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [20:0] exp_lookup();
        for (int i = 0; i < N; i++) begin
            logic ok;
            ok = 1'b0;
            if (m_val[i] && m_page[i] == lk_page) begin
                if (!nest_en)
                    ok = !lk_gpa && m_kind[i] == 2'd0 && m_vpid[i] == cur_vpid &&
                         (m_glob[i] || m_pcid[i] == cur_pcid);
                else if (lk_gpa)
                    ok = m_kind[i] == 2'd2 && m_root[i] == cur_root;
                else
                    ok = m_kind[i] == 2'd1 && m_vpid[i] == cur_vpid &&
                         m_root[i] == cur_root && (m_glob[i] || m_pcid[i] == cur_pcid);
            end
            if (ok) return {1'b1, m_frame[i]};
        end
        return 21'd0;
    endfunction

    function automatic logic killed(int i);
        logic ll;
        ll = m_val[i] && (m_kind[i] == 2'd0 || m_kind[i] == 2'd1);
        case (inv_cmd)
            3'd0: return ll && m_vpid[i] == cur_vpid && m_page[i] == inv_page;
            3'd1: return (m_val[i] && m_kind[i] == 2'd2 && m_root[i] == cur_root &&
                          m_page[i] == inv_page) ||
                         (inv_lin_valid && m_val[i] && m_kind[i] == 2'd1 &&
                          m_vpid[i] == cur_vpid && m_root[i] == cur_root &&
                          (m_glob[i] || m_pcid[i] == cur_pcid) && m_page[i] == inv_lin_page);
            3'd2: return ll && m_vpid[i] == 16'd0;
            3'd3: return ll && m_vpid[i] == inv_vpid && m_page[i] == inv_page;
            default: return 1'b0;
        endcase
    endfunction

    // Checks the current cycle, advances the model, moves to the next negedge.
    task automatic run_cycle();
        logic [20:0] e;
        string tag;
        #1;
        e = exp_lookup();
        tag = !nest_en ? "R1 lookup" : (lk_gpa ? "R3 lookup" : "R2 lookup");
        chk(tag, {11'd0, lk_hit, lk_frame}, {11'd0, e});
        chk("R9 unsup flag", inv_unsup, m_unsup);
        if (inv_en) begin
            if (inv_cmd <= 3'd3)
                for (int i = 0; i < N; i++) if (killed(i)) m_val[i] = 1'b0;
            m_unsup = inv_cmd > 3'd3;
        end else begin
            m_unsup = 1'b0;
            if (fill_en && fill_kind != 2'd3) begin
                m_val[m_ptr] = 1'b1;        m_kind[m_ptr] = fill_kind;
                m_glob[m_ptr] = fill_global; m_vpid[m_ptr] = fill_vpid;
                m_pcid[m_ptr] = fill_pcid;   m_root[m_ptr] = fill_root;
                m_page[m_ptr] = fill_page;   m_frame[m_ptr] = fill_frame;
                m_ptr = (m_ptr + 1) % N;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        fill_en = 1'b0;
        inv_en = 1'b0;
        inv_lin_valid = 1'b0;
    endtask

    task automatic fill(logic [1:0] k, logic g, logic [15:0] v, logic [11:0] p,
                        logic [11:0] r, logic [19:0] pg, logic [19:0] fr);
        idle();
        fill_en = 1'b1; fill_kind = k; fill_global = g; fill_vpid = v;
        fill_pcid = p; fill_root = r; fill_page = pg; fill_frame = fr;
        run_cycle();
        idle();
    endtask

    task automatic flush(logic [2:0] c, logic [19:0] pg, logic [15:0] v,
                         logic lv, logic [19:0] lpg);
        idle();
        inv_en = 1'b1; inv_cmd = c; inv_page = pg; inv_vpid = v;
        inv_lin_valid = lv; inv_lin_page = lpg;
        run_cycle();
        idle();
    endtask

    task automatic probe(string req, logic ne, logic gpa, logic [15:0] v,
                         logic [11:0] p, logic [11:0] r, logic [19:0] pg, logic exp);
        idle();
        nest_en = ne; lk_gpa = gpa; cur_vpid = v; cur_pcid = p; cur_root = r; lk_page = pg;
        #1;
        chk(req, lk_hit, exp);
        run_cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) m_val[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R12 reset hit", lk_hit, 1'b0);
        chk("R12 reset unsup", inv_unsup, 1'b0);
        @(negedge clk);

        // R1/R2/R4 kinds and modes
        fill(2'd0, 1'b0, 16'd1, 12'd2, 12'd0, 20'd5, 20'h11111);
        probe("R1 linear hit", 1'b0, 1'b0, 16'd1, 12'd2, 12'd0, 20'd5, 1'b1);
        probe("R1 pcid mismatch", 1'b0, 1'b0, 16'd1, 12'd3, 12'd0, 20'd5, 1'b0);
        fill(2'd1, 1'b0, 16'd1, 12'd2, 12'd3, 20'd5, 20'h22222);
        probe("R2 combined hit", 1'b1, 1'b0, 16'd1, 12'd2, 12'd3, 20'd5, 1'b1);
        #1 chk("R2 combined frame", lk_frame, 20'h22222);
        probe("R4 linear again", 1'b0, 1'b0, 16'd1, 12'd2, 12'd3, 20'd5, 1'b1);
        #1 chk("R4 linear frame", lk_frame, 20'h11111);
        fill(2'd2, 1'b0, 16'd7, 12'd7, 12'd3, 20'd9, 20'h33333);
        probe("R3 gpa hit", 1'b1, 1'b1, 16'd0, 12'd0, 12'd3, 20'd9, 1'b1);
        probe("R1 gpa miss nest off", 1'b0, 1'b1, 16'd0, 12'd0, 12'd3, 20'd9, 1'b0);

        // R5 single page
        cur_vpid = 16'd1; nest_en = 1'b0; cur_root = 12'd0;
        flush(3'd0, 20'd5, 16'd0, 1'b0, 20'd0);
        probe("R5 combined gone", 1'b1, 1'b0, 16'd1, 12'd2, 12'd3, 20'd5, 1'b0);
        probe("R5 linear gone", 1'b0, 1'b0, 16'd1, 12'd2, 12'd3, 20'd5, 1'b0);
        probe("R5 gpa kept", 1'b1, 1'b1, 16'd1, 12'd2, 12'd3, 20'd9, 1'b1);

        // R6 nested fault
        fill(2'd1, 1'b0, 16'd2, 12'd1, 12'd3, 20'd7, 20'h44444);
        fill(2'd2, 1'b0, 16'd0, 12'd0, 12'd3, 20'd8, 20'h55555);
        cur_vpid = 16'd2; cur_pcid = 12'd1; cur_root = 12'd3;
        flush(3'd1, 20'd8, 16'd0, 1'b1, 20'd7);
        probe("R6 gpa gone", 1'b1, 1'b1, 16'd2, 12'd1, 12'd3, 20'd8, 1'b0);
        probe("R6 combined gone", 1'b1, 1'b0, 16'd2, 12'd1, 12'd3, 20'd7, 1'b0);
        probe("R6 other gpa kept", 1'b1, 1'b1, 16'd2, 12'd1, 12'd3, 20'd9, 1'b1);

        // R7 world switch
        fill(2'd0, 1'b0, 16'd0, 12'd4, 12'd0, 20'd1, 20'h66666);
        fill(2'd1, 1'b0, 16'd0, 12'd5, 12'd2, 20'd1, 20'h77777);
        fill(2'd0, 1'b0, 16'd1, 12'd0, 12'd0, 20'd1, 20'h88888);
        flush(3'd2, 20'd0, 16'd0, 1'b0, 20'd0);
        probe("R7 vpid0 linear gone", 1'b0, 1'b0, 16'd0, 12'd4, 12'd0, 20'd1, 1'b0);
        probe("R7 vpid0 combined gone", 1'b1, 1'b0, 16'd0, 12'd5, 12'd2, 20'd1, 1'b0);
        probe("R7 vpid1 kept", 1'b0, 1'b0, 16'd1, 12'd0, 12'd0, 20'd1, 1'b1);

        // R8 individual address
        fill(2'd0, 1'b1, 16'd2, 12'd6, 12'd0, 20'd3, 20'h99999);
        fill(2'd1, 1'b0, 16'd2, 12'd7, 12'd1, 20'd3, 20'haaaaa);
        cur_vpid = 16'd0;
        flush(3'd3, 20'd3, 16'd2, 1'b0, 20'd0);
        probe("R8 linear gone", 1'b0, 1'b0, 16'd2, 12'd9, 12'd0, 20'd3, 1'b0);
        probe("R8 combined gone", 1'b1, 1'b0, 16'd2, 12'd7, 12'd1, 20'd3, 1'b0);

        // R9 unsupported
        flush(3'd5, 20'd1, 16'd1, 1'b0, 20'd0);
        probe("R9 entries unchanged", 1'b0, 1'b0, 16'd1, 12'd0, 12'd0, 20'd1, 1'b1);

        // R11 flush beats fill; same-cycle lookup sees old state
        fill(2'd0, 1'b0, 16'd0, 12'd0, 12'd0, 20'd13, 20'hbbbbb);
        idle();
        nest_en = 1'b0; lk_gpa = 1'b0; cur_vpid = 16'd0; cur_pcid = 12'd0; lk_page = 20'd13;
        inv_en = 1'b1; inv_cmd = 3'd2;
        fill_en = 1'b1; fill_kind = 2'd0; fill_vpid = 16'd1; fill_pcid = 12'd0; fill_page = 20'd12;
        #1 chk("R11 same-cycle lookup", lk_hit, 1'b1);
        run_cycle();
        idle();
        probe("R11 flushed after", 1'b0, 1'b0, 16'd0, 12'd0, 12'd0, 20'd13, 1'b0);
        probe("R11 fill dropped", 1'b0, 1'b0, 16'd1, 12'd0, 12'd0, 20'd12, 1'b0);

        // R10 round robin
        for (int i = 0; i < N; i++)
            fill(2'd0, 1'b0, 16'd3, 12'd0, 12'd0, 20'd100 + 20'(i), 20'h100 + 20'(i));
        probe("R10 oldest present", 1'b0, 1'b0, 16'd3, 12'd0, 12'd0, 20'd100, 1'b1);
        fill(2'd0, 1'b0, 16'd3, 12'd0, 12'd0, 20'd116, 20'h116);
        probe("R10 oldest evicted", 1'b0, 1'b0, 16'd3, 12'd0, 12'd0, 20'd100, 1'b0);
        fill(2'd3, 1'b0, 16'd3, 12'd0, 12'd0, 20'd200, 20'h200);
        fill(2'd0, 1'b0, 16'd3, 12'd0, 12'd0, 20'd117, 20'h117);
        probe("R10 kind3 no advance", 1'b0, 1'b0, 16'd3, 12'd0, 12'd0, 20'd101, 1'b0);
        probe("R10 next kept", 1'b0, 1'b0, 16'd3, 12'd0, 12'd0, 20'd102, 1'b1);
        probe("R12 lowest slot wins", 1'b0, 1'b0, 16'd3, 12'd0, 12'd0, 20'd117, 1'b1);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int r;
            idle();
            r = int'($urandom_range(0, 9));
            nest_en = 1'($urandom_range(0, 1));
            lk_gpa = 1'($urandom_range(0, 1));
            cur_vpid = 16'($urandom_range(0, 2));
            cur_pcid = 12'($urandom_range(0, 2));
            cur_root = 12'($urandom_range(0, 1));
            lk_page = 20'($urandom_range(0, 7));
            if (r < 5) begin
                fill_en = 1'b1;
                fill_kind = 2'($urandom_range(0, 3));
                fill_global = 1'($urandom_range(0, 1));
                fill_vpid = 16'($urandom_range(0, 2));
                fill_pcid = 12'($urandom_range(0, 2));
                fill_root = 12'($urandom_range(0, 1));
                fill_page = 20'($urandom_range(0, 7));
                fill_frame = 20'($urandom);
            end
            if (r >= 4 && r < 7) begin
                inv_en = 1'b1;
                inv_cmd = 3'($urandom_range(0, 7));
                inv_page = 20'($urandom_range(0, 7));
                inv_vpid = 16'($urandom_range(0, 2));
                inv_lin_valid = 1'($urandom_range(0, 1));
                inv_lin_page = 20'($urandom_range(0, 7));
            end
            run_cycle();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule